// File: doc/BRIEF.md
# Shared Global Timer with Per-Core Comparators

This block provides one free-running 64-bit up-counter that several cores share, plus a private event unit for each core. Every core owns a 64-bit comparator, a 32-bit auto-increment step, a small set of control bits and one event flag. The block drives one interrupt line per core. A core reaches its private view through a 32-bit register bus. The bus carries the core index with each access. The counter words read the same from every core.

The counter advances once every `prescale + 1` clocks while the shared enable is set. A core's event flag is raised whenever that core's comparator is enabled and the counter has reached the comparator value. With auto-increment on, each match adds the step to that core's comparator, so events repeat at a fixed period without software help. Reading the two counter halves consistently is left to software.

Bus reads are combinational from the addressed core's state. Writes take effect at the next rising clock edge.

Top module: `global_timer_cmp`

## Requirements
- R1: The counter is 64 bits wide and counts upward, wrapping from all ones to zero. While the timer-enable bit is set it advances by one every `prescale + 1` clocks. Any core reads its low word at offset 0x00 and its high word at offset 0x04.
- R2: A write to 0x00 or 0x04 loads that counter word only while the timer-enable bit is clear. While the timer is enabled, such a write is ignored.
- R3: The control word is at 0x08. Bit 0 is timer enable and bits 15:8 are the prescale value; these two fields are shared, and a control write from any core updates them. Bit 1 (comparator enable), bit 2 (interrupt enable) and bit 3 (auto-increment) belong to the writing core. A read returns the shared fields together with the reading core's own bits, and every other bit reads 0.
- R4: The comparator low and high words are at 0x10 and 0x14 and the increment step is at 0x18. All three are held per core and read back as written. Any other offset reads 0.
- R5: The event flag is status bit 0 at 0x0C. It is set at the clock edge after a cycle in which the core's comparator is enabled and the counter is greater than or equal to the comparator. The interrupt-enable bit has no influence on this.
- R6: When auto-increment is on, each matching cycle adds the zero-extended step to that core's comparator at the next edge. A bus write to either comparator word in the same cycle takes precedence over the addition.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. If a match occurs in the same cycle as the clear, the flag stays set.
- R8: Each interrupt output equals that core's event flag ANDed with its interrupt-enable bit, with no added delay.
- R9: After reset, the counter, prescaler, every control bit, comparator, step and flag are zero, and all interrupt outputs are low.
- R10: A write that carries core index i never changes another core's comparator, step, control bits 3:1 or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_core | input | CIDX_W | Index of the core making the access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed core and offset |
| irq | output | NCORE | One interrupt line per core |

## Verification
Two collisions matter in this block. The first is a compare match landing in the same cycle as a software flag clear. The bench provokes it by clearing a flag while the counter still sits at or above that core's comparator, and judges that the flag stays set (R7). The second is an auto-increment step meeting a software comparator write in the same cycle. The bench provokes it by arming a core with a step of one and a comparator behind the counter, so that it matches every cycle, then writing the comparator; the written value must win (R6). The behavioural reference model compares every interrupt line on every clock and each register read, so any wrong priority shows up in the cycle it occurs.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

    localparam int CB_RUN    = 0;
    localparam int CB_CMP    = 1;
    localparam int CB_IRQ    = 2;
    localparam int CB_AINC   = 3;
    localparam int CB_PRE_LO = 8;

    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_en;
    } core_ctl_t;
endpackage

// File: rtl/gt_count.sv
module gt_count #(
    parameter int CNT_W  = 64,
    parameter int PRE_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    localparam int HI_W = CNT_W - WORD_W;

    logic [PRE_W-1:0] pdiv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pdiv <= '0;
        end else if (!run) begin
            pdiv <= '0;
            if (wr_lo) cnt[WORD_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
        end else if (pdiv == pre) begin
            pdiv <= '0;
            cnt  <= cnt + 1'b1;
        end else begin
            pdiv <= pdiv + 1'b1;
        end
    end

    // R1: while running the counter moves by at most one per clock
    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R2: halted and not written, the counter holds
    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/gt_core.sv
module gt_core
    import gt_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_ctl,
    input  logic              wr_clr,
    input  logic              wr_cmp_lo,
    input  logic              wr_cmp_hi,
    input  logic              wr_step,
    input  logic [WORD_W-1:0] wdata,
    output core_ctl_t         ctl,
    output logic [CNT_W-1:0]  cmp,
    output logic [STEP_W-1:0] step,
    output logic              flag,
    output logic              irq
);
    localparam int HI_W = CNT_W - WORD_W;

    logic hit;
    assign hit = ctl.cmp_en && (cnt >= cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl  <= '0;
            step <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.cmp_en   <= wdata[CB_CMP];
                ctl.irq_en   <= wdata[CB_IRQ];
                ctl.auto_inc <= wdata[CB_AINC];
            end
            if (wr_step) step <= wdata[STEP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (wr_cmp_lo || wr_cmp_hi) begin
            if (wr_cmp_lo) cmp[WORD_W-1:0]     <= wdata;
            if (wr_cmp_hi) cmp[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
        end else if (hit && ctl.auto_inc) begin
            cmp <= cmp + CNT_W'(step);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hit)    flag <= 1'b1;
        else if (wr_clr) flag <= 1'b0;
    end

    assign irq = flag & ctl.irq_en;

    // R5: a match always leaves the flag set
    a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R6: an unopposed auto-increment advances the comparator by the step
    a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctl.auto_inc && !wr_cmp_lo && !wr_cmp_hi)
        |=> cmp == $past(cmp) + CNT_W'($past(step)));

    // R7: a clear without a competing match drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !hit) |=> !flag);

    // R8: a masked core never interrupts
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.irq_en |-> !irq);
endmodule

// File: rtl/global_timer_cmp.sv
module global_timer_cmp
    import gt_pkg::*;
#(
    parameter int NCORE  = 2,
    parameter int PRE_W  = 8,
    parameter int STEP_W = 32,
    localparam int CIDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [CIDX_W-1:0]     bus_core,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [NCORE-1:0]      irq
);
    logic             run;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;

    logic wr_ctl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
    assign wr_ctl    = bus_we && (bus_addr == OFS_CTRL);
    assign wr_stat   = bus_we && (bus_addr == OFS_STAT) && bus_wdata[0];
    assign wr_cmp_lo = bus_we && (bus_addr == OFS_CMP_LO);
    assign wr_cmp_hi = bus_we && (bus_addr == OFS_CMP_HI);
    assign wr_step   = bus_we && (bus_addr == OFS_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            pre <= '0;
        end else if (wr_ctl) begin
            run <= bus_wdata[CB_RUN];
            pre <= bus_wdata[CB_PRE_LO +: PRE_W];
        end
    end

    gt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .WORD_W(WORD_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .pre   (pre),
        .wr_lo (bus_we && (bus_addr == OFS_CNT_LO)),
        .wr_hi (bus_we && (bus_addr == OFS_CNT_HI)),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    core_ctl_t         c_ctl  [NCORE];
    logic [CNT_W-1:0]  c_cmp  [NCORE];
    logic [STEP_W-1:0] c_step [NCORE];
    logic              c_flag [NCORE];

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        logic mine;
        assign mine = (bus_core == CIDX_W'(g));
        gt_core #(.CNT_W(CNT_W), .STEP_W(STEP_W), .WORD_W(WORD_W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .wr_ctl    (mine && wr_ctl),
            .wr_clr    (mine && wr_stat),
            .wr_cmp_lo (mine && wr_cmp_lo),
            .wr_cmp_hi (mine && wr_cmp_hi),
            .wr_step   (mine && wr_step),
            .wdata     (bus_wdata),
            .ctl       (c_ctl[g]),
            .cmp       (c_cmp[g]),
            .step      (c_step[g]),
            .flag      (c_flag[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (bus_core == CIDX_W'(i)) begin
                unique case (bus_addr)
                    OFS_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
                    OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD_W];
                    OFS_CTRL: begin
                        bus_rdata[CB_RUN]             = run;
                        bus_rdata[CB_CMP]             = c_ctl[i].cmp_en;
                        bus_rdata[CB_IRQ]             = c_ctl[i].irq_en;
                        bus_rdata[CB_AINC]            = c_ctl[i].auto_inc;
                        bus_rdata[CB_PRE_LO +: PRE_W] = pre;
                    end
                    OFS_STAT:   bus_rdata[0] = c_flag[i];
                    OFS_CMP_LO: bus_rdata = c_cmp[i][WORD_W-1:0];
                    OFS_CMP_HI: bus_rdata = c_cmp[i][CNT_W-1:WORD_W];
                    OFS_STEP:   bus_rdata = WORD_W'(c_step[i]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    // R3: the shared enable only changes through a control write
    a_r3_run_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(run));
endmodule

// File: tb/sim_global_timer_cmp.sv
`timescale 1ns/1ps
module sim_global_timer_cmp;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [0:0]  core = '0;
    logic [4:0]  addr = '0;
    logic [31:0] wd = '0;
    wire  [31:0] rd;
    wire  [NC-1:0] irq;

    always #2 clk = ~clk;

    global_timer_cmp #(.NCORE(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_core(core),
        .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd), .irq(irq)
    );

    int nvec = 0;
    int nbad = 0;

    // behavioural reference state
    longint unsigned m_cnt;
    int unsigned     m_pdiv, m_pre;
    bit              m_en;
    longint unsigned m_cmp [NC];
    int unsigned     m_inc [NC];
    bit m_ce [NC];
    bit m_ie [NC];
    bit m_ai [NC];
    bit m_flag [NC];

    always @(posedge clk) begin : ref_model
        longint unsigned n_cnt;
        int unsigned     n_pdiv;
        bit              hit;
        if (!rst_n) begin
            m_cnt = 0; m_pdiv = 0; m_pre = 0; m_en = 0;
            for (int c = 0; c < NC; c++) begin
                m_cmp[c] = 0; m_inc[c] = 0; m_ce[c] = 0;
                m_ie[c] = 0; m_ai[c] = 0; m_flag[c] = 0;
            end
        end else begin
            n_cnt = m_cnt; n_pdiv = m_pdiv;
            if (m_en) begin
                if (m_pdiv == m_pre) begin n_pdiv = 0; n_cnt = m_cnt + 1; end
                else n_pdiv = (m_pdiv + 1) & 255;
            end else begin
                n_pdiv = 0;
                if (we && addr == 5'h00) n_cnt = {m_cnt[63:32], wd};
                if (we && addr == 5'h04) n_cnt = {wd, m_cnt[31:0]};
            end
            for (int c = 0; c < NC; c++) begin
                hit = m_ce[c] && (m_cnt >= m_cmp[c]);
                if (we && core == c[0:0] && (addr == 5'h10 || addr == 5'h14)) begin
                    if (addr == 5'h10) m_cmp[c] = {m_cmp[c][63:32], wd};
                    else               m_cmp[c] = {wd, m_cmp[c][31:0]};
                end else if (hit && m_ai[c]) begin
                    m_cmp[c] = m_cmp[c] + 64'(m_inc[c]);
                end
                if (hit) m_flag[c] = 1;
                else if (we && core == c[0:0] && addr == 5'h0C && wd[0]) m_flag[c] = 0;
                if (we && core == c[0:0] && addr == 5'h18) m_inc[c] = wd;
                if (we && core == c[0:0] && addr == 5'h08) begin
                    m_ce[c] = wd[1]; m_ie[c] = wd[2]; m_ai[c] = wd[3];
                end
            end
            if (we && addr == 5'h08) begin m_en = wd[0]; m_pre = wd[15:8]; end
            m_cnt = n_cnt; m_pdiv = n_pdiv;
        end
    end

    function automatic logic [31:0] mread(int c, logic [4:0] a);
        case (a)
            5'h00: return m_cnt[31:0];
            5'h04: return m_cnt[63:32];
            5'h08: return {16'h0, m_pre[7:0], 4'h0, m_ai[c], m_ie[c], m_ce[c], m_en};
            5'h0C: return {31'h0, m_flag[c]};
            5'h10: return m_cmp[c][31:0];
            5'h14: return m_cmp[c][63:32];
            5'h18: return m_inc[c];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // R8: every interrupt line against flag AND enable, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NC; c++)
                check("R8 irq", 32'(irq[c]), 32'(m_flag[c] & m_ie[c]));
        end
    end

    task automatic wr(int c, logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; core = c[0:0]; addr = a; wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdchk(int c, logic [4:0] a, string tag);
        @(negedge clk);
        core = c[0:0]; addr = a;
        #1;
        check(tag, rd, mread(c, a));
    endtask

    task automatic rdall(string tag);
        logic [4:0] offs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18};
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 7; k++) rdchk(c, offs[k], tag);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: everything zero after reset, checked against hard zeros
        for (int c = 0; c < NC; c++) begin
            for (int a = 0; a < 28; a += 4) begin
                @(negedge clk); core = c[0:0]; addr = 5'(a); #1;
                check("R9 reset", rd, 32'h0);
            end
            check("R9 irq reset", 32'(irq[c]), 32'h0);
        end

        // R2: counter loads while halted; carry into the high word later (R1)
        wr(0, 5'h00, 32'hFFFF_FFF0);
        wr(1, 5'h04, 32'h0000_0000);
        rdchk(0, 5'h00, "R2 load lo");
        rdchk(1, 5'h00, "R1 shared view");
        // R4: per-core comparator and step
        wr(0, 5'h10, 32'h0000_0004); wr(0, 5'h14, 32'h1); wr(0, 5'h18, 32'd6);
        wr(1, 5'h10, 32'h0000_0010); wr(1, 5'h14, 32'h1); wr(1, 5'h18, 32'd1);
        rdall("R4 readback");
        rdchk(0, 5'h1C, "R4 unmapped");

        // R3: core0 enables the shared counter, core1 sets only its own bits
        wr(0, 5'h08, 32'h0000_000F);
        wr(1, 5'h08, 32'h0000_0003);
        rdall("R3 ctrl views");
        // R2: write ignored while running
        wr(1, 5'h00, 32'h0);
        rdchk(0, 5'h00, "R2 ignored");
        idle(30);
        rdall("R1 carry R5 flags R10");
        // R5: core1 flag set although its interrupt is masked
        rdchk(1, 5'h0C, "R5 masked flag");

        // R7: writing 0 does nothing; clear while still matching keeps flag
        wr(1, 5'h0C, 32'h0);
        rdchk(1, 5'h0C, "R7 write zero");
        wr(1, 5'h0C, 32'h1);
        rdchk(1, 5'h0C, "R7 set wins");
        wr(1, 5'h08, 32'h0000_0001);
        wr(1, 5'h0C, 32'h1);
        rdchk(1, 5'h0C, "R7 cleared");

        // R6: core0 periodic events, cleared each time
        for (int k = 0; k < 6; k++) begin
            wr(0, 5'h0C, 32'h1);
            idle(4);
            rdchk(0, 5'h10, "R6 rearm");
            rdchk(0, 5'h0C, "R6 flag");
        end

        // R6: core1 auto-increment each cycle, then a colliding comparator write
        wr(1, 5'h08, 32'h0000_000B);
        idle(5);
        rdchk(1, 5'h10, "R6 step one");
        wr(1, 5'h10, 32'h0000_0100);
        rdchk(1, 5'h10, "R6 write wins");
        wr(1, 5'h14, 32'hFFFF_0000);
        rdall("R6 R10 after collision");

        // R1: prescale of 3
        wr(0, 5'h08, 32'h0000_030F);
        idle(21);
        rdall("R1 prescale");
        rdchk(1, 5'h00, "R1 prescale lo");

        // R1: wrap at 64 bits
        wr(0, 5'h08, 32'h0000_000E);
        wr(0, 5'h00, 32'hFFFF_FFFD);
        wr(0, 5'h04, 32'hFFFF_FFFF);
        rdchk(0, 5'h04, "R2 load hi");
        wr(1, 5'h08, 32'h0000_0005);
        idle(6);
        rdchk(0, 5'h00, "R1 wrap lo");
        rdchk(0, 5'h04, "R1 wrap hi");
        rdall("R10 final");
        wr(1, 5'h0C, 32'h1);
        idle(3);
        rdall("R8 R5 final");

        summary();
        $finish;
    end
endmodule